// File: doc/BRIEF.md
# Three-Axis Remapped Index Sequencer

This block walks a three-axis nested loop and emits, one per accepted step, the flat element index that the current loop position maps to. A 32-bit shape word, sampled on `start`, sets the three axis sizes, which axis is the innermost, middle and outermost loop, whether each axis counts up or down, a constant added to every index, and an optional axis whose coordinate is left out of the flat index. A separate vector-length input caps how many indices a run produces.

A consumer pulses `start` with the shape word and length, then raises `step` whenever it takes the index shown on `idx_out`. `idx_valid` stays high while an index is on offer and `idx_last` marks the final one. Shape words that ask for an indexed permutation or a non-zero mode are refused: `unsupported` goes high and no index is offered.

Top module: `remap_idx_gen`

## Requirements
- R1: The shape word is split as bits [31:26] x size code, [25:20] y size code, [19:14] z size code, [13:11] permute code, [10:8] direction bits (bit 10 x, bit 9 y, bit 8 z), [7:4] offset, [3:2] skip code, [1:0] mode; each size code c gives an axis of c+1 positions (1 to 64).
- R2: Permute codes 0 to 5 give innermost-first loop orders (x,y,z), (x,z,y), (y,x,z), (y,z,x), (z,x,y), (z,y,x); the innermost axis advances on every step and each outer axis advances when all inner axes wrap.
- R3: An axis whose direction bit is 0 runs 0 up to size-1; with the bit set it runs size-1 down to 0.
- R4: The flat index is x + y·X + z·X·Y, where X and Y are the x and y axis sizes.
- R5: Skip code 1 drops the x term, 2 drops the y term, 3 drops the z term, 0 drops none; the skipped axis still iterates.
- R6: The 4-bit offset is added to every emitted index.
- R7: A run emits at most `vec_len` indices (1 to 127) and stops early when the length is reached.
- R8: `idx_last` is high exactly with the final index of a run; `idx_valid` is low the cycle after that index is taken.
- R9: Permute codes 6 or 7, or a non-zero mode, raise `unsupported` from the cycle after `start` until the next `start`, with `idx_valid` held low; an accepted word clears it.
- R10: While `idx_valid` is high and `step` is low, `idx_out` and `idx_valid` hold their values.
- R11: After reset, `idx_valid`, `idx_last` and `unsupported` are low.
- R12: The first index of a run appears the cycle after `start`; each step taken at an edge shows the next index the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load the shape word and length, begin a run |
| step | input | 1 | Consumer takes the index on offer |
| shape_cfg | input | 32 | Shape configuration word |
| vec_len | input | 7 | Maximum number of indices for the run |
| idx_out | output | 19 | Current remapped index |
| idx_valid | output | 1 | An index is on offer |
| idx_last | output | 1 | The offered index is the run's final one |
| unsupported | output | 1 | The loaded shape word is refused |

## Verification
A wrong axis counter or carry shows up at the ports as an index out of the expected order, at the very step where the faulty wrap or carry first happens, so the element-by-element comparison against an independently computed sequence pins it to one step. A wrong element count or terminal detection shows as `idx_last` on the wrong element or `idx_valid` lingering the cycle after the final step. Refused words are checked for a silent output over several step requests, and stalls are mixed into every run to expose indices that drift while not taken.

// File: rtl/remap_pkg.sv
// Shared types for the remapped index sequencer.
// Assumes the 32-bit shape word layout given in the brief (MSB first).
package remap_pkg;

    localparam int DIM_W  = 6;
    localparam int AXES   = 3;
    localparam int AXIS_W = 2;

    typedef struct packed {
        logic [DIM_W-1:0] xm;
        logic [DIM_W-1:0] ym;
        logic [DIM_W-1:0] zm;
        logic [2:0]       perm;
        logic [2:0]       inv;    // [2] x, [1] y, [0] z
        logic [3:0]       off;
        logic [1:0]       skip;
        logic [1:0]       mode;
    } shape_t;

    typedef struct packed {
        logic              ok;
        logic [AXIS_W-1:0] a2;   // outermost
        logic [AXIS_W-1:0] a1;
        logic [AXIS_W-1:0] a0;   // innermost
    } axis_order_t;

    // Map a permute code to innermost-first axis numbers (0 x, 1 y, 2 z).
    function automatic axis_order_t order_of(input logic [2:0] perm);
        axis_order_t o;
        o = '{ok: 1'b1, a2: 2'd2, a1: 2'd1, a0: 2'd0};
        case (perm)
            3'd0: o = '{ok: 1'b1, a2: 2'd2, a1: 2'd1, a0: 2'd0};
            3'd1: o = '{ok: 1'b1, a2: 2'd1, a1: 2'd2, a0: 2'd0};
            3'd2: o = '{ok: 1'b1, a2: 2'd2, a1: 2'd0, a0: 2'd1};
            3'd3: o = '{ok: 1'b1, a2: 2'd0, a1: 2'd2, a0: 2'd1};
            3'd4: o = '{ok: 1'b1, a2: 2'd1, a1: 2'd0, a0: 2'd2};
            3'd5: o = '{ok: 1'b1, a2: 2'd0, a1: 2'd1, a0: 2'd2};
            default: o.ok = 1'b0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/remap_axis_ctr.sv
// One loop axis: holds its size and direction, counts up or down and
// wraps back to its start position. Assumes adv is only raised while a run
// is active; load takes priority over adv.
module remap_axis_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_size,
    input  logic         ld_inv,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output logic         at_term
);

    logic [W-1:0] size_q;
    logic         inv_q;

    // Terminal position depends on the counting direction.
    always_comb begin
        at_term = inv_q ? (cnt == '0) : (cnt == size_q);
    end

    // Load start position, or step / wrap the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            inv_q  <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            size_q <= ld_size;
            inv_q  <= ld_inv;
            cnt    <= ld_inv ? ld_size : '0;
        end else if (adv) begin
            if (at_term)
                cnt <= inv_q ? size_q : '0;
            else if (inv_q)
                cnt <= cnt - 1'b1;
            else
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/remap_index_calc.sv
// Flattens the three axis positions into one index, dropping the skipped
// axis term and adding the offset. Purely combinational; assumes the
// result fits in IDX_W bits (guaranteed by the default width).
module remap_index_calc #(
    parameter int W     = 6,
    parameter int IDX_W = 3*W + 1
) (
    input  logic [W-1:0]     pos_x,
    input  logic [W-1:0]     pos_y,
    input  logic [W-1:0]     pos_z,
    input  logic [W-1:0]     xm,
    input  logic [W-1:0]     ym,
    input  logic [1:0]       skip,
    input  logic [3:0]       off,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] xs, ys, tx, ty, tz;

    // Weighted sum of the axis terms.
    always_comb begin
        xs  = IDX_W'(xm) + IDX_W'(1);
        ys  = IDX_W'(ym) + IDX_W'(1);
        tx  = (skip == 2'd1) ? '0 : IDX_W'(pos_x);
        ty  = (skip == 2'd2) ? '0 : IDX_W'(pos_y) * xs;
        tz  = (skip == 2'd3) ? '0 : IDX_W'(pos_z) * xs * ys;
        idx = tx + ty + tz + IDX_W'(off);
    end

endmodule

// File: rtl/remap_idx_gen.sv
// Top of the remapped index sequencer. Samples a shape word on start,
// runs three nested axis counters in the selected order and offers one
// flat index per step. Assumes step is ignored while no index is offered.
module remap_idx_gen
    import remap_pkg::*;
#(
    parameter int VL_W  = 7,
    parameter int IDX_W = 3*remap_pkg::DIM_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [31:0]      shape_cfg,
    input  logic [VL_W-1:0]  vec_len,
    output logic [IDX_W-1:0] idx_out,
    output logic             idx_valid,
    output logic             idx_last,
    output logic             unsupported
);

    shape_t      cfg_in;
    axis_order_t ord_in, ord_q;
    logic        accept;

    logic             active, unsup_q;
    logic [VL_W-1:0]  cnt_q, vl_q;
    logic [DIM_W-1:0] xm_q, ym_q;
    logic [3:0]       off_q;
    logic [1:0]       skip_q;

    logic [DIM_W-1:0] ld_size [AXES];
    logic [DIM_W-1:0] pos     [AXES];
    logic [AXES-1:0]  term, adv, ld_inv;
    logic             go, all_term, vl_hit;

    // Decode the incoming shape word.
    always_comb begin
        cfg_in     = shape_t'(shape_cfg);
        ord_in     = order_of(cfg_in.perm);
        accept     = ord_in.ok && (cfg_in.mode == 2'b00);
        ld_size[0] = cfg_in.xm;
        ld_size[1] = cfg_in.ym;
        ld_size[2] = cfg_in.zm;
        ld_inv     = {cfg_in.inv[0], cfg_in.inv[1], cfg_in.inv[2]};
    end

    // End-of-run detection and step qualification.
    always_comb begin
        all_term = &term;
        vl_hit   = (cnt_q == vl_q - VL_W'(1));
        idx_last = active && (all_term || vl_hit);
        go       = active && step && !start;
    end

    // Carry chain through the selected loop order.
    always_comb begin
        adv = '0;
        if (go) begin
            adv[ord_q.a0] = 1'b1;
            if (term[ord_q.a0])
                adv[ord_q.a1] = 1'b1;
            if (term[ord_q.a0] && term[ord_q.a1])
                adv[ord_q.a2] = 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < AXES; g++) begin : g_axis
            remap_axis_ctr #(.W(DIM_W)) axis_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (start),
                .ld_size (ld_size[g]),
                .ld_inv  (ld_inv[g]),
                .adv     (adv[g]),
                .cnt     (pos[g]),
                .at_term (term[g])
            );
        end
    endgenerate

    remap_index_calc #(.W(DIM_W), .IDX_W(IDX_W)) calc_i (
        .pos_x (pos[0]),
        .pos_y (pos[1]),
        .pos_z (pos[2]),
        .xm    (xm_q),
        .ym    (ym_q),
        .skip  (skip_q),
        .off   (off_q),
        .idx   (idx_out)
    );

    // Run control: load on start, count taken indices, stop at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            unsup_q <= 1'b0;
            cnt_q   <= '0;
            vl_q    <= '0;
            xm_q    <= '0;
            ym_q    <= '0;
            off_q   <= '0;
            skip_q  <= '0;
            ord_q   <= '0;
        end else if (start) begin
            active  <= accept && (vec_len != '0);
            unsup_q <= !accept;
            cnt_q   <= '0;
            vl_q    <= vec_len;
            xm_q    <= cfg_in.xm;
            ym_q    <= cfg_in.ym;
            off_q   <= cfg_in.off;
            skip_q  <= cfg_in.skip;
            ord_q   <= ord_in;
        end else if (go) begin
            if (idx_last)
                active <= 1'b0;
            else
                cnt_q <= cnt_q + VL_W'(1);
        end
    end

    assign idx_valid   = active;
    assign unsupported = unsup_q;

endmodule

// File: rtl/remap_idx_chk.sv
// Port-level checker for the index sequencer, bound into every instance.
// Tracks the taken-index count itself to check the length cap.
module remap_idx_chk #(
    parameter int VL_W  = 7,
    parameter int IDX_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             step,
    input logic [VL_W-1:0]  vec_len,
    input logic [IDX_W-1:0] idx_out,
    input logic             idx_valid,
    input logic             idx_last,
    input logic             unsupported
);

    logic [VL_W:0]   taken;
    logic [VL_W-1:0] vl_l;

    // Count indices taken since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken <= '0;
            vl_l  <= '0;
        end else if (start) begin
            taken <= '0;
            vl_l  <= vec_len;
        end else if (idx_valid && step) begin
            taken <= taken + 1'b1;
        end
    end

    assert_unsup_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> !idx_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && !step && !start) |=> (idx_valid && $stable(idx_out)));

    assert_stop_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && idx_last && step && !start) |=> !idx_valid);

    assert_continue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && !idx_last && step && !start) |=> idx_valid);

    assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |-> (taken < {1'b0, vl_l}));

    assert_last_only_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_last |-> idx_valid);

endmodule

bind remap_idx_gen remap_idx_chk #(.VL_W(VL_W), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .step        (step),
    .vec_len     (vec_len),
    .idx_out     (idx_out),
    .idx_valid   (idx_valid),
    .idx_last    (idx_last),
    .unsupported (unsupported)
);

// File: tb/remap_idx_gen_tb_top.sv
// Scoreboard bench: the driver computes each run's index sequence from the
// requirements and queues it; the monitor pops and compares at negedge.
module remap_idx_gen_tb_top;

    localparam int VL_W  = 7;
    localparam int IDX_W = 19;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             step = 1'b0;
    logic [31:0]      shape_cfg = '0;
    logic [VL_W-1:0]  vec_len = '0;
    logic [IDX_W-1:0] idx_out;
    logic             idx_valid, idx_last, unsupported;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string cur_tag = "R11";
    logic [7:0] lfsr = 8'h5a;
    logic hold_seen = 1'b0;
    logic [IDX_W-1:0] hold_idx = '0;
    int cycles = 0;

    always #10 clk = ~clk;

    remap_idx_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .shape_cfg(shape_cfg), .vec_len(vec_len), .idx_out(idx_out),
        .idx_valid(idx_valid), .idx_last(idx_last), .unsupported(unsupported)
    );

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input int xm, ym, zm, perm, inv, off, skip, mode);
        return {6'(xm), 6'(ym), 6'(zm), 3'(perm), 3'(inv), 4'(off), 2'(skip), 2'(mode)};
    endfunction

    // Expected sequence from R1-style field split and loop rules.
    task automatic push_expected(input logic [31:0] w, input int vl);
        int sz[3], inv[3], ord[3], p[3], v[3];
        int perm, off, skip, n, idx;
        sz[0] = int'(w[31:26]) + 1;
        sz[1] = int'(w[25:20]) + 1;
        sz[2] = int'(w[19:14]) + 1;
        perm  = int'(w[13:11]);
        inv[0] = int'(w[10]); inv[1] = int'(w[9]); inv[2] = int'(w[8]);
        off   = int'(w[7:4]);
        skip  = int'(w[3:2]);
        case (perm)
            0: ord = '{0, 1, 2};
            1: ord = '{0, 2, 1};
            2: ord = '{1, 0, 2};
            3: ord = '{1, 2, 0};
            4: ord = '{2, 0, 1};
            default: ord = '{2, 1, 0};
        endcase
        n = 0;
        for (int c = 0; c < sz[ord[2]]; c++)
            for (int b = 0; b < sz[ord[1]]; b++)
                for (int a = 0; a < sz[ord[0]]; a++) begin
                    p[ord[0]] = a; p[ord[1]] = b; p[ord[2]] = c;
                    for (int g = 0; g < 3; g++)
                        v[g] = inv[g] != 0 ? sz[g] - 1 - p[g] : p[g];
                    idx = off;
                    if (skip != 1) idx += v[0];
                    if (skip != 2) idx += v[1] * sz[0];
                    if (skip != 3) idx += v[2] * sz[0] * sz[1];
                    if (n < vl) exp_q.push_back(idx);
                    n++;
                end
    endtask

    // Driver: queue expectations, start, step with stalls until drained.
    task automatic run_case(input logic [31:0] w, input int vl, input string tag);
        int guard;
        cur_tag = tag;
        push_expected(w, vl);
        @(posedge clk); #2;
        shape_cfg = w; vec_len = VL_W'(vl); start = 1'b1; step = 1'b0;
        @(posedge clk); #2;
        start = 1'b0;
        check({tag, " R9 flag clear"}, unsupported == 1'b0, int'(unsupported), 0);
        check({tag, " R12 first offered"}, idx_valid == 1'b1, int'(idx_valid), 1);
        guard = 0;
        forever begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step = (lfsr[1:0] != 2'b00);
            @(posedge clk); #2;
            guard++;
            if (exp_q.size() == 0 || guard > 4000) break;
        end
        step = 1'b0;
        check({tag, " R7 all expected produced"}, exp_q.size() == 0, exp_q.size(), 0);
        check({tag, " R8 valid drops after last"}, idx_valid == 1'b0, int'(idx_valid), 0);
        exp_q.delete();
    endtask

    task automatic run_refused(input logic [31:0] w, input string tag);
        @(posedge clk); #2;
        shape_cfg = w; vec_len = 7'd10; start = 1'b1; step = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check({tag, " R9 unsupported high"}, unsupported == 1'b1, int'(unsupported), 1);
            check({tag, " R9 no index offered"}, idx_valid == 1'b0, int'(idx_valid), 0);
        end
        @(posedge clk); #2;
        step = 1'b0;
    endtask

    // Monitor: compare each taken index, its last flag, and hold behaviour.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_seen) begin
                check({cur_tag, " R10 hold valid"}, idx_valid == 1'b1, int'(idx_valid), 1);
                check({cur_tag, " R10 hold index"}, idx_out == hold_idx, int'(idx_out), int'(hold_idx));
            end
            hold_seen = idx_valid && !step && !start;
            hold_idx  = idx_out;
            if (idx_valid && step && !start) begin
                if (exp_q.size() == 0) begin
                    check({cur_tag, " R7 extra index"}, 1'b0, int'(idx_out), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check({cur_tag, " R2/R3/R4/R5/R6 index"}, idx_out == IDX_W'(e), int'(idx_out), e);
                    check({cur_tag, " R8 last flag"}, idx_last == (exp_q.size() == 0),
                          int'(idx_last), int'(exp_q.size() == 0));
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 valid in reset", idx_valid == 1'b0, int'(idx_valid), 0);
        check("R11 last in reset", idx_last == 1'b0, int'(idx_last), 0);
        check("R11 unsupported in reset", unsupported == 1'b0, int'(unsupported), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 valid after reset", idx_valid == 1'b0, int'(idx_valid), 0);

        run_case(mk(2, 1, 0, 0, 0, 0, 0, 0), 127, "R1 R4 plain");
        run_case(mk(1, 1, 2, 2, 0, 0, 0, 0), 127, "R2 swap xy");
        run_case(mk(2, 1, 3, 5, 5, 0, 0, 0), 127, "R3 reverse order inv");
        run_case(mk(3, 2, 1, 1, 7, 0, 2, 0), 127, "R5 skip y inv all");
        run_case(mk(2, 2, 1, 3, 0, 5, 1, 0), 127, "R6 offset skip x");
        run_case(mk(1, 3, 2, 4, 2, 9, 3, 0), 127, "R5 skip z");
        run_case(mk(3, 3, 3, 0, 0, 0, 0, 0), 10, "R7 truncated");
        run_case(mk(7, 7, 7, 4, 1, 15, 0, 0), 127, "R7 cap 127");
        run_case(mk(0, 0, 0, 0, 7, 3, 0, 0), 127, "R8 single");
        run_case(mk(63, 0, 0, 0, 4, 0, 0, 0), 127, "R1 wide x");
        run_refused(mk(1, 1, 1, 6, 0, 0, 0, 0), "perm6");
        run_refused(mk(1, 1, 1, 7, 0, 0, 0, 0), "perm7");
        run_refused(mk(1, 1, 1, 0, 0, 0, 0, 1), "mode1");
        run_case(mk(1, 2, 1, 2, 0, 1, 0, 0), 127, "R9 recovery");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule